// File: doc/BRIEF.md
# Palette Table Controller

This block holds one palette: a table of up to 256 entries, 32 bits each, that turns an indexed pixel into a colour word. The parent instantiates one copy for each of its two pixel sources, so each source has its own palette. The table can be filled in two ways. In the first, an automatic load reads a programmed number of entries from memory through a request/response stream. In the second, a processor writes entries directly, and only full 32-bit writes are allowed. A lookup port returns the entry for a 4-bit or 8-bit index one cycle after the index is accepted.

An automatic load starts with a one-cycle pulse on `load_start`. At that pulse the block latches the base address, the entry count minus one, and the memory format. Format 0 means each memory word is one complete ARGB entry. Format 1 means the entries are packed 3-byte RGB triplets, which the block unpacks and stores with the alpha byte forced to 0xFF. While a load runs, the lookup port de-asserts its ready, so a pending lookup waits until the load ends. A one-cycle done pulse marks the end of the load.

All data streams use valid/ready. A request is issued when `rd_req_valid` and `rd_req_ready` are both high in the same cycle; until then the request holds its address. A response word is consumed only in a cycle where `rd_rsp_valid` and `rd_rsp_ready` are both high, so the memory side may stall in either direction. The lookup port takes an index when `lk_valid` and `lk_ready` are both high. Its result has a fixed latency and cannot be back-pressured.

Top module: `pal_table_ctrl`

## Requirements
- R1: A lookup is accepted when `lk_valid` and `lk_ready` are both high in a cycle. `ent_valid` is high in exactly the next cycle, with `ent_data` equal to the stored entry, and is low in every other cycle.
- R2: When `lk_narrow` is 1, only `lk_idx[3:0]` selects the entry (zero-extended), so only entries 0 to 15 can be reached; the upper index bits have no effect.
- R3: A processor write with `cpu_wr_be` = 4'hF while no load is running stores `cpu_wr_data` at `cpu_wr_idx`, and `cpu_wr_err` stays 0.
- R4: A processor write with any `cpu_wr_be` bit clear drives `cpu_wr_err` high in that same cycle and leaves the table unchanged.
- R5: In format 0, a load requests `load_size_m1`+1 words at byte addresses base+4k, and entry k receives word k.
- R6: In format 1, a load requests ceil(3N/4) words, where N = `load_size_m1`+1. Bytes within a word are little-endian: the byte at address A sits in bits [8*(A mod 4)+7 : 8*(A mod 4)]. Entry k is {8'hFF, byte[base+3k+2], byte[base+3k+1], byte[base+3k]}.
- R7: Entries with an index above `load_size_m1` keep their contents across a load.
- R8: While `load_busy` is high, `lk_ready` is 0. A lookup held valid during a load completes after the load and returns the newly loaded entry.
- R9: `load_done` is high for exactly one cycle, in the first cycle where `load_busy` is low after a load.
- R10: While a load is running, a `load_start` pulse is ignored (no extra requests are made), and a processor write is rejected with `cpu_wr_err` high and no change to the table.
- R11: A request that is not yet accepted keeps `rd_req_valid` high and `rd_req_addr` stable. Requests are issued and responses accepted only while a load is running.
- R12: After reset: `load_busy`, `load_done`, `rd_req_valid`, `rd_rsp_ready` and `ent_valid` are 0, and `lk_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Starts an automatic load (ignored while busy) |
| load_fmt | input | 1 | Memory format: 0 word per entry, 1 packed RGB triplets |
| load_base | input | ADDR_W | Byte address of the first entry (low two bits ignored) |
| load_size_m1 | input | IDX_W | Number of entries to load, minus one |
| load_busy | output | 1 | A load is in progress |
| load_done | output | 1 | One-cycle pulse at load completion |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Word-aligned byte address of the request |
| rd_rsp_valid | input | 1 | Response word valid |
| rd_rsp_ready | output | 1 | Block accepts the response word |
| rd_rsp_data | input | 32 | Response word |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_wr_be | input | 4 | Byte enables of the write |
| cpu_wr_idx | input | IDX_W | Entry written |
| cpu_wr_data | input | 32 | Entry value |
| cpu_wr_err | output | 1 | The current write is rejected |
| lk_valid | input | 1 | Lookup index valid |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_narrow | input | 1 | Index is 4 bits wide |
| lk_idx | input | IDX_W | Lookup index |
| ent_valid | output | 1 | Lookup result valid |
| ent_data | output | 32 | Looked-up entry |

## Verification
The assertions check on every cycle the parts that can be decided locally in time. These are: the one-cycle lookup latency; the closed lookup port during a load; the stability of a request that has not been accepted; the limit that stream traffic happens only while busy; the single-cycle done pulse at the fall of busy; and the rule that a partial-enable write never reaches the storage write port. Only the bench scenarios can show that stored contents are correct. That covers exhaustive sweeps after processor fills, word-per-entry loads and packed-triplet loads under stalling memory, entries above the load size left untouched, reduced-width indexing, and a stalled lookup that returns freshly loaded data.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int ENT_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int WORD_BE = ENT_W / BYTE_W;

  typedef enum logic {
    SRC_ARGB = 1'b0,
    SRC_RGB  = 1'b1
  } src_fmt_e;

  localparam logic [BYTE_W-1:0] OPAQUE_A = 8'hFF;
endpackage

// File: rtl/pal_req_gen.sv
// Issues word read requests for one automatic load.
module pal_req_gen
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  src_fmt_e          fmt,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  size_m1,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr
);
  localparam int CW = IDX_W + 3;

  logic [CW-1:0]     ent_n, rgb_bytes, rgb_words, word_n;
  logic [CW-1:0]     left_q;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    ent_n     = {3'b000, size_m1} + CW'(1);
    rgb_bytes = (ent_n << 1) + ent_n;
    rgb_words = (rgb_bytes + CW'(3)) >> 2;
    word_n    = (fmt == SRC_RGB) ? rgb_words : ent_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      addr_q <= '0;
    end else if (start) begin
      left_q <= word_n;
      addr_q <= base & ~ADDR_W'(3);
    end else if (req_valid && req_ready) begin
      left_q <= left_q - CW'(1);
      addr_q <= addr_q + ADDR_W'(WORD_BE);
    end
  end

  assign req_valid = (left_q != '0);
  assign req_addr  = addr_q;
endmodule

// File: rtl/pal_unpack.sv
// Turns response words into table entries, one per cycle at most.
module pal_unpack
  import pal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  src_fmt_e         fmt,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [ENT_W-1:0] rsp_data,
  output logic             out_valid,
  output logic [ENT_W-1:0] out_data
);
  localparam int BUF_W = 6 * BYTE_W;
  localparam int TRI_W = 3 * BYTE_W;

  logic [BUF_W-1:0] buf_q, buf_rem, buf_nxt;
  logic [2:0]       cnt_q, cnt_rem, cnt_nxt;
  logic [5:0]       sh;
  logic             pop, take;

  always_comb begin
    pop     = en && (fmt == SRC_RGB) && (cnt_q >= 3'd3);
    cnt_rem = pop ? cnt_q - 3'd3 : cnt_q;
    buf_rem = pop ? (buf_q >> TRI_W) : buf_q;
    if (fmt == SRC_RGB) begin
      rsp_ready = en && (cnt_rem <= 3'd2);
      out_valid = pop;
      out_data  = {OPAQUE_A, buf_q[TRI_W-1:0]};
    end else begin
      rsp_ready = en;
      out_valid = en && rsp_valid;
      out_data  = rsp_data;
    end
    take    = rsp_valid && rsp_ready && (fmt == SRC_RGB);
    sh      = {cnt_rem, 3'b000};
    buf_nxt = take ? (buf_rem | (BUF_W'(rsp_data) << sh)) : buf_rem;
    cnt_nxt = cnt_rem + (take ? 3'd4 : 3'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else begin
      buf_q <= buf_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/pal_store.sv
// Entry storage with a registered lookup read.
module pal_store
  import pal_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int NARROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [ENT_W-1:0] wdata,
  input  logic             rd_fire,
  input  logic             rd_narrow,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [ENT_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] idx_eff;

  generate
    if (IDX_W > NARROW_W) begin : g_narrow
      assign idx_eff = rd_narrow ? {{(IDX_W-NARROW_W){1'b0}}, rd_idx[NARROW_W-1:0]}
                                 : rd_idx;
    end else begin : g_flat
      logic unused_narrow;
      assign unused_narrow = rd_narrow;
      assign idx_eff = rd_idx;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= mem[idx_eff];
    end
  end
endmodule

// File: rtl/pal_table_ctrl.sv
module pal_table_ctrl
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic              load_fmt,
  input  logic [ADDR_W-1:0] load_base,
  input  logic [IDX_W-1:0]  load_size_m1,
  output logic              load_busy,
  output logic              load_done,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [31:0]       rd_rsp_data,
  input  logic              cpu_wr_en,
  input  logic [3:0]        cpu_wr_be,
  input  logic [IDX_W-1:0]  cpu_wr_idx,
  input  logic [31:0]       cpu_wr_data,
  output logic              cpu_wr_err,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic              lk_narrow,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              ent_valid,
  output logic [31:0]       ent_data
);
  logic             busy_q, done_q;
  src_fmt_e         fmt_q;
  logic [IDX_W-1:0] size_q, fill_cnt;
  logic             start_acc, fill_we, cpu_ok, st_we, lk_fire;
  logic [IDX_W-1:0] st_widx;
  logic [ENT_W-1:0] fill_data, st_wdata;

  assign start_acc = load_start && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      fmt_q    <= SRC_ARGB;
      size_q   <= '0;
      fill_cnt <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_acc) begin
        busy_q   <= 1'b1;
        fmt_q    <= src_fmt_e'(load_fmt);
        size_q   <= load_size_m1;
        fill_cnt <= '0;
      end else if (busy_q && fill_we) begin
        fill_cnt <= fill_cnt + IDX_W'(1);
        if (fill_cnt == size_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  pal_req_gen #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_acc),
    .fmt       (src_fmt_e'(load_fmt)),
    .base      (load_base),
    .size_m1   (load_size_m1),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .req_addr  (rd_req_addr)
  );

  pal_unpack u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start_acc),
    .en        (busy_q),
    .fmt       (fmt_q),
    .rsp_valid (rd_rsp_valid),
    .rsp_ready (rd_rsp_ready),
    .rsp_data  (rd_rsp_data),
    .out_valid (fill_we),
    .out_data  (fill_data)
  );

  assign cpu_ok     = cpu_wr_en && (cpu_wr_be == 4'hF) && !busy_q;
  assign cpu_wr_err = cpu_wr_en && !cpu_ok;
  assign st_we      = fill_we || cpu_ok;
  assign st_widx    = busy_q ? fill_cnt : cpu_wr_idx;
  assign st_wdata   = busy_q ? fill_data : cpu_wr_data;
  assign lk_ready   = !busy_q;
  assign lk_fire    = lk_valid && lk_ready;

  pal_store #(.IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (st_we),
    .widx      (st_widx),
    .wdata     (st_wdata),
    .rd_fire   (lk_fire),
    .rd_narrow (lk_narrow),
    .rd_idx    (lk_idx),
    .rd_valid  (ent_valid),
    .rd_data   (ent_data)
  );

  assign load_busy = busy_q;
  assign load_done = done_q;
endmodule

// File: rtl/pal_table_ctrl_chk.sv
module pal_table_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              ent_valid,
  input logic              load_busy,
  input logic              load_done,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_ready,
  input logic              cpu_wr_en,
  input logic [3:0]        cpu_wr_be,
  input logic              st_we
);
  // R1
  lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> ent_valid);
  // R1
  no_stray_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> !ent_valid);
  // R8
  stall_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy |-> !lk_ready);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  // R11
  req_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid || rd_rsp_ready) |-> load_busy);
  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (!load_busy && $past(load_busy)));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);
  // R4
  partial_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && (cpu_wr_be != 4'hF) && !load_busy) |-> !st_we);
endmodule

bind pal_table_ctrl pal_table_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_ready     (lk_ready),
  .ent_valid    (ent_valid),
  .load_busy    (load_busy),
  .load_done    (load_done),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_ready (rd_rsp_ready),
  .cpu_wr_en    (cpu_wr_en),
  .cpu_wr_be    (cpu_wr_be),
  .st_we        (st_we)
);

// File: tb/pal_table_ctrl_tb.sv
`timescale 1ns/1ps
module pal_table_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_start = 1'b0, load_fmt = 1'b0;
  logic [31:0] load_base = '0;
  logic [7:0]  load_size_m1 = '0;
  logic        load_busy, load_done;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [31:0] rd_req_addr, rd_rsp_data;
  logic        cpu_wr_en = 1'b0;
  logic [3:0]  cpu_wr_be = '0;
  logic [7:0]  cpu_wr_idx = '0;
  logic [31:0] cpu_wr_data = '0;
  logic        cpu_wr_err;
  logic        lk_valid = 1'b0, lk_narrow = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic        lk_ready, ent_valid;
  logic [31:0] ent_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int req_hs = 0;
  logic stall = 1'b0;

  always #4 clk = ~clk;

  pal_table_ctrl u_dut (.*);

  function automatic logic [7:0] mb(input logic [31:0] a);
    logic [31:0] t;
    t = (a * 32'd37) ^ (a >> 4) ^ 32'h5A;
    return t[7:0];
  endfunction
  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {mb(a + 3), mb(a + 2), mb(a + 1), mb(a)};
  endfunction
  function automatic logic [31:0] rgb_ent(input logic [31:0] b, input int k);
    logic [31:0] a;
    a = b + 32'(3 * k);
    return {8'hFF, mb(a + 2), mb(a + 1), mb(a)};
  endfunction
  function automatic logic [31:0] cpu_pat(input int k);
    logic [7:0] b;
    b = 8'(k);
    return {b, ~b, 8'(k * 3), 8'hA5};
  endfunction

  // memory model: ordered request queue with optional stalls
  logic [31:0] q_addr [16];
  logic [3:0]  q_wr = '0, q_rd = '0;
  logic [4:0]  q_cnt = '0;
  logic        push, pop;
  assign rd_req_ready = (q_cnt < 5'd14) && (!stall || (cyc % 3 != 0));
  assign rd_rsp_valid = (q_cnt != 5'd0) && (!stall || (cyc % 4 != 1));
  assign rd_rsp_data  = word_at(q_addr[q_rd]);
  assign push = rd_req_valid && rd_req_ready;
  assign pop  = rd_rsp_valid && rd_rsp_ready;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_wr <= '0; q_rd <= '0; q_cnt <= '0;
    end else begin
      if (push) begin
        q_addr[q_wr] <= rd_req_addr;
        q_wr <= q_wr + 4'd1;
        req_hs <= req_hs + 1;
      end
      if (pop) q_rd <= q_rd + 4'd1;
      q_cnt <= q_cnt + {4'd0, push} - {4'd0, pop};
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <150000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [7:0] idx, input logic narrow, output logic [31:0] d);
    lk_valid = 1'b1; lk_idx = idx; lk_narrow = narrow;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    chk("R1 valid after accept", 32'(ent_valid), 32'd1);
    d = ent_data;
    lk_valid = 1'b0;
  endtask

  task automatic cpu_write(input logic [7:0] idx, input logic [3:0] be,
                           input logic [31:0] d, output logic err);
    cpu_wr_en = 1'b1; cpu_wr_be = be; cpu_wr_idx = idx; cpu_wr_data = d;
    #1 err = cpu_wr_err;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic run_load(input logic [31:0] base, input logic [7:0] sz,
                          input logic fmt, input int exp_words);
    int hs0, dn;
    hs0 = req_hs; dn = 0;
    load_base = base; load_size_m1 = sz; load_fmt = fmt; load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    chk("R8 busy after start", 32'(load_busy), 32'd1);
    do begin
      @(negedge clk);
      if (load_done) dn++;
    end while (load_busy);
    chk("R9 done at busy fall", 32'(dn), 32'd1);
    @(negedge clk);
    chk("R9 done one cycle", 32'(load_done), 32'd0);
    chk(fmt ? "R6 word count" : "R5 word count", 32'(req_hs - hs0), 32'(exp_words));
  endtask

  initial begin
    logic [31:0] d;
    logic e;
    int hs0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 busy", 32'(load_busy), 32'd0);
    chk("R12 done", 32'(load_done), 32'd0);
    chk("R12 req", 32'(rd_req_valid), 32'd0);
    chk("R12 rsp ready", 32'(rd_rsp_ready), 32'd0);
    chk("R12 ent valid", 32'(ent_valid), 32'd0);
    chk("R12 lk ready", 32'(lk_ready), 32'd1);

    // R3 full-width writes, then exhaustive lookup sweep (R1)
    for (int k = 0; k < 256; k++) begin
      cpu_write(8'(k), 4'hF, cpu_pat(k), e);
      chk("R3 no err", 32'(e), 32'd0);
    end
    for (int k = 0; k < 256; k++) begin
      lookup(8'(k), 1'b0, d);
      chk("R3 R1 entry", d, cpu_pat(k));
    end
    @(negedge clk);
    chk("R1 valid drops", 32'(ent_valid), 32'd0);

    // R4 partial writes rejected
    for (int b = 0; b < 15; b++) begin
      cpu_write(8'd9, 4'(b), 32'hDEAD_BEEF, e);
      chk("R4 err", 32'(e), 32'd1);
    end
    lookup(8'd9, 1'b0, d);
    chk("R4 unchanged", d, cpu_pat(9));

    // R2 narrow index ignores upper bits
    for (int i = 0; i < 16; i++) begin
      lookup({4'(15 - i) | 4'h8, 4'(i)}, 1'b1, d);
      chk("R2 narrow entry", d, cpu_pat(i));
    end

    // R5 word-per-entry load, stalling memory
    stall = 1'b1;
    run_load(32'h1000, 8'd255, 1'b0, 256);
    for (int k = 0; k < 256; k++) begin
      lookup(8'(k), 1'b0, d);
      chk("R5 entry", d, word_at(32'h1000 + 32'(4 * k)));
    end

    // R6 packed load of 5 entries; R7 rest untouched
    run_load(32'h2000, 8'd4, 1'b1, 4);
    for (int k = 0; k < 11; k++) begin
      lookup(8'(k), 1'b0, d);
      if (k < 5) chk("R6 short entry", d, rgb_ent(32'h2000, k));
      else       chk("R7 kept entry", d, word_at(32'h1000 + 32'(4 * k)));
    end

    // R6 full packed load, no stalls, misaligned base bits ignored
    stall = 1'b0;
    run_load(32'h3002, 8'd255, 1'b1, 192);
    for (int k = 0; k < 256; k++) begin
      lookup(8'(k), 1'b0, d);
      chk("R6 entry", d, rgb_ent(32'h3000, k));
    end

    // R8 R10 activity during a load
    stall = 1'b1;
    hs0 = req_hs;
    load_base = 32'h4000; load_size_m1 = 8'd63; load_fmt = 1'b0; load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    chk("R8 lk_ready low", 32'(lk_ready), 32'd0);
    cpu_write(8'd200, 4'hF, 32'h1234_5678, e);
    chk("R10 write rejected", 32'(e), 32'd1);
    load_base = 32'h8000; load_size_m1 = 8'd200; load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    lookup(8'd63, 1'b0, d);
    chk("R8 stalled lookup new data", d, word_at(32'h4000 + 32'(4 * 63)));
    repeat (4) @(negedge clk);
    chk("R10 start ignored", 32'(req_hs - hs0), 32'd64);
    chk("R10 busy ended", 32'(load_busy), 32'd0);
    lookup(8'd200, 1'b0, d);
    chk("R10 entry kept", d, rgb_ent(32'h3000, 200));
    lookup(8'd64, 1'b0, d);
    chk("R7 above size kept", d, rgb_ent(32'h3000, 64));

    summary();
  end
endmodule